// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Bit Slip

This block gathers a serial bit stream into 8-bit parallel words and emits a framing clock that marks word boundaries. It runs in one of two rates, chosen by a static rate input. In double rate, each clock cycle carries two serial bits. They arrive as two pre-sampled lanes: lane A holds the earlier bit and lane B the later one. In single rate, each rising edge carries one bit on lane A, and lane B is not used.

Alignment is adjusted with a slip request. The request is asynchronous, so it is synchronized first and then qualified by its length. Once accepted, it discards exactly one serial bit, which moves every following word boundary by one bit position. A clock enable freezes all state cleanly. A one-cycle strobe accompanies each new word.

Top module: `deser_slip`

## Requirements
- R1: The first serial bit kept after reset or after a discard-free run lands in `word_out[0]`, and the eighth lands in `word_out[7]`.
- R2: With `rate_sel`=0 (double rate), every enabled cycle takes lane A and then lane B, so a new word appears every 4 enabled cycles.
- R3: With `rate_sel`=1 (single rate), every enabled cycle takes only lane A, so a new word appears every 8 enabled cycles; lane B has no effect on any output.
- R4: After each enabled edge, `frame_clk` is high exactly when 4 to 7 bits of the word in progress are held, and low otherwise. This gives a divide-by-4 clock in double rate and a divide-by-8 clock in single rate, and `frame_clk` is low whenever `word_vld` is high.
- R5: `word_vld` is high for one cycle with each new word, and `word_out` changes only in such a cycle.
- R6: In double rate, a slip request seen high on 2 consecutive rising edges, starting at edge t, discards the lane A bit of the cycle at edge t+4.
- R7: In single rate, a slip request seen high on 3 consecutive rising edges, starting at edge t, discards the lane A bit of the cycle at edge t+5.
- R8: A slip request held one edge shorter than its rate requires discards nothing.
- R9: One request pulse discards one bit however long it is held. The request must be seen low before it can be qualified again.
- R10: While `clk_en` is low at a rising edge, that edge changes nothing. The data bits, word, frame clock and slip qualification all freeze, and `word_vld` is low. Capture resumes with the first edge at which `clk_en` is high.
- R11: A synchronous active-low `rst_n` clears the partial word, the bit count, the slip qualifier and `word_out`, and drives `frame_clk` and `word_vld` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_sel | input | 1 | 0 = two bits per cycle, 1 = one bit per cycle (static) |
| lane_a | input | 1 | Earlier serial bit of the cycle |
| lane_b | input | 1 | Later serial bit of the cycle (double rate only) |
| slip_req | input | 1 | Asynchronous request to discard one bit |
| clk_en | input | 1 | Active-high enable; low freezes the block |
| word_out | output | 8 | Last completed word, oldest bit in bit 0 |
| word_vld | output | 1 | One-cycle strobe with each new word |
| frame_clk | output | 1 | Word-framing clock |

## Verification
If the bit count is wrong, `frame_clk` shows it in the very next cycle, because its level follows the count of held bits. A corrupt partial word shows up at the next `word_vld`, at most 8 cycles later. If the slip qualifier misfires, or fails to fire, every later word is shifted by one position. The discard edge is fixed relative to the request, so that shift is visible at the first strobe after it.

// File: rtl/deser_slip_pkg.sv
// Package: shared parameters and the rate type for the deserializer.
// Assumes: rate selection is static while data flows.
package deser_slip_pkg;
    typedef enum logic {
        RATE_DOUBLE = 1'b0,
        RATE_SINGLE = 1'b1
    } rate_e;

    localparam int LANES = 2;
endpackage

// File: rtl/deser_slip_sync.sv
// Multi-flop synchronizer for an asynchronous single-bit level.
// Assumes: the input is a level that stays stable for several clocks; it
// runs regardless of clock enable so it never holds a stale sample.
module deser_slip_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] pipe;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], async_in};
    end

    assign sync_out = pipe[STAGES-1];
endmodule

// File: rtl/deser_slip_qual.sv
// Slip qualifier: measures how long the synchronized request stays high.
// Once the hold reaches the count for the current rate, it arms a one-shot
// discard. It re-arms only after the request has been seen low.
// Assumes: drop_pend is consumed at the next enabled edge.
module deser_slip_qual
    import deser_slip_pkg::*;
#(
    parameter int DBL_HOLD = 2,
    parameter int SGL_HOLD = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  rate_e rate,
    input  logic  req_s,
    output logic  drop_pend
);
    localparam int MAX_HOLD = (DBL_HOLD > SGL_HOLD) ? DBL_HOLD : SGL_HOLD;
    localparam int HW       = $clog2(MAX_HOLD + 1);

    logic [HW-1:0] hold;
    logic [HW-1:0] need;
    logic          armed;

    // Required hold length for the current rate.
    always_comb need = (rate == RATE_SINGLE) ? HW'(SGL_HOLD) : HW'(DBL_HOLD);

    // Count the request length, fire once, and wait for release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold      <= '0;
            armed     <= 1'b1;
            drop_pend <= 1'b0;
        end else if (en) begin
            if (drop_pend) drop_pend <= 1'b0;
            if (!req_s) begin
                hold  <= '0;
                armed <= 1'b1;
            end else if (armed) begin
                if (hold + 1'b1 == need) begin
                    drop_pend <= 1'b1;
                    armed     <= 1'b0;
                    hold      <= '0;
                end else begin
                    hold <= hold + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/deser_slip_pack.sv
// Bit packer: places up to LANES bits per cycle into a partial word,
// oldest bit at index 0. It publishes the word when it fills and derives
// the framing clock from the number of bits held.
// Assumes: a drop removes the lane A bit of the same cycle.
module deser_slip_pack
    import deser_slip_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  rate_e             rate,
    input  logic              lane_a,
    input  logic              lane_b,
    input  logic              drop,
    output logic [WORD_W-1:0] word_q,
    output logic              vld_q,
    output logic              frame_q
);
    localparam int CW   = $clog2(WORD_W);
    localparam int HALF = WORD_W / 2;

    logic [WORD_W-1:0] acc, acc_n, word_n;
    logic [CW-1:0]     cnt, cnt_n;
    logic              done;
    logic [LANES-1:0]  take, bits;

    // Decide which lanes carry bits this cycle and pack them in order.
    always_comb begin
        bits    = {lane_b, lane_a};
        take[0] = !drop;
        take[1] = (rate == RATE_DOUBLE);
        acc_n   = acc;
        cnt_n   = cnt;
        word_n  = word_q;
        done    = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (take[i]) begin
                acc_n[cnt_n] = bits[i];
                if (cnt_n == CW'(WORD_W - 1)) begin
                    word_n = acc_n;
                    done   = 1'b1;
                    acc_n  = '0;
                    cnt_n  = '0;
                end else begin
                    cnt_n = cnt_n + 1'b1;
                end
            end
        end
    end

    // Commit packing state on enabled edges; the strobe drops otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            cnt     <= '0;
            word_q  <= '0;
            vld_q   <= 1'b0;
            frame_q <= 1'b0;
        end else if (en) begin
            acc     <= acc_n;
            cnt     <= cnt_n;
            word_q  <= word_n;
            vld_q   <= done;
            frame_q <= (cnt_n >= CW'(HALF));
        end else begin
            vld_q   <= 1'b0;
        end
    end
endmodule

// File: rtl/deser_slip.sv
// Top of the serial-to-parallel deserializer with bit slip. It chains the
// request synchronizer, the slip qualifier and the bit packer.
// Assumes: rate_sel is static; the lanes are already sampled into clk.
module deser_slip
    import deser_slip_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int SYNC_STG = 2,
    parameter int DBL_HOLD = 2,
    parameter int SGL_HOLD = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_sel,
    input  logic              lane_a,
    input  logic              lane_b,
    input  logic              slip_req,
    input  logic              clk_en,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld,
    output logic              frame_clk
);
    rate_e rate;
    logic  req_s;
    logic  drop_pend;

    // Map the mode pin onto the rate type.
    always_comb rate = rate_e'(rate_sel);

    deser_slip_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (slip_req),
        .sync_out (req_s)
    );

    deser_slip_qual #(.DBL_HOLD(DBL_HOLD), .SGL_HOLD(SGL_HOLD)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (clk_en),
        .rate      (rate),
        .req_s     (req_s),
        .drop_pend (drop_pend)
    );

    deser_slip_pack #(.WORD_W(WORD_W)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (clk_en),
        .rate    (rate),
        .lane_a  (lane_a),
        .lane_b  (lane_b),
        .drop    (drop_pend),
        .word_q  (word_out),
        .vld_q   (word_vld),
        .frame_q (frame_clk)
    );
endmodule

// File: rtl/deser_slip_chk.sv
// Checker for deser_slip: port-level timing properties, bound to the top.
module deser_slip_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic [WORD_W-1:0] word_out,
    input logic              word_vld,
    input logic              frame_clk
);
    AST_VLD_FRAME_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> !frame_clk); // R4
    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld); // R5
    AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> $stable(word_out) || word_vld); // R5
    AST_DISABLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(frame_clk) && !word_vld)); // R10
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!frame_clk && !word_vld && word_out == '0)); // R11
endmodule

bind deser_slip deser_slip_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .word_out  (word_out),
    .word_vld  (word_vld),
    .frame_clk (frame_clk)
);

// File: tb/test_deser_slip.sv
// Bench: sweeps both rates through alignment, short and long slip pulses,
// re-arm and enable gaps, predicting each word and frame level arithmetically.
module test_deser_slip;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rate_sel = 1'b0;
    logic       lane_a = 1'b0, lane_b = 1'b0, slip_req = 1'b0, clk_en = 1'b1;
    logic [7:0] word_out;
    logic       word_vld, frame_clk;

    int total = 0, bad = 0;
    bit finished = 0;
    int edge_n = 0;
    int drop_at = -100;
    int pos = 0;
    logic [7:0] cur = '0, last_word = '0, exp_word = '0;
    bit exp_vld = 0;
    logic [15:0] lfsr = 16'hACE1;
    string tag = "R2";
    int words_seen = 0;

    always #5 clk = ~clk;

    deser_slip i_deser_slip (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .lane_a(lane_a),
        .lane_b(lane_b), .slip_req(slip_req), .clk_en(clk_en),
        .word_out(word_out), .word_vld(word_vld), .frame_clk(frame_clk)
    );

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", t, act, exp);
        end
    endtask

    function automatic logic rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // One clock: drive at negedge, model the edge, check at the next negedge.
    task automatic tick(input logic a, input logic b, input logic r, input logic e);
        lane_a = a; lane_b = b; slip_req = r; clk_en = e;
        @(posedge clk);
        exp_vld = 0;
        if (e) begin
            for (int i = 0; i < 2; i++) begin
                if (i == 1 && rate_sel) continue;
                if (i == 0 && edge_n == drop_at) continue;
                cur[pos] = (i == 0) ? a : b;
                pos++;
                if (pos == 8) begin
                    exp_word = cur; exp_vld = 1; pos = 0; cur = '0;
                end
            end
        end
        edge_n++;
        @(negedge clk);
        chk(word_vld == exp_vld, e ? "R5" : "R10", word_vld, exp_vld);
        if (exp_vld) begin
            chk(word_out == exp_word, tag, word_out, exp_word);
            last_word = exp_word;
            words_seen++;
        end else begin
            chk(word_out == last_word, e ? "R5" : "R10", word_out, last_word);
        end
        chk(frame_clk == (pos >= 4), e ? "R4" : "R10", frame_clk, (pos >= 4));
    endtask

    task automatic run(input int n, input logic r);
        for (int k = 0; k < n; k++) tick(rnd(), rnd(), r, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; clk_en = 1'b1; slip_req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        pos = 0; cur = '0; last_word = '0; drop_at = -100; edge_n = 0;
        chk(word_out == 8'h00 && !word_vld && !frame_clk, "R11",
            {word_vld, frame_clk, word_out}, 0);
    endtask

    // Slip pulse of length len; predicted discard edge when long enough.
    task automatic slip(input int len);
        int need;
        need = rate_sel ? 3 : 2;
        if (len >= need) drop_at = edge_n + 2 + need;
        run(len, 1'b1);
        run(12, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < 2; m++) begin
            rate_sel = m[0];
            do_reset();
            tag = "R1";
            tick(1'b1, 1'b0, 1'b0, 1'b1);
            for (int k = 0; k < 7; k++) tick(1'b0, 1'b0, 1'b0, 1'b1);
            tag = m ? "R3" : "R2";
            words_seen = 0;
            run(32, 1'b0);
            chk(words_seen == (m ? 4 : 8), tag, words_seen, m ? 4 : 8);
            tag = "R8";
            slip(m ? 2 : 1);
            tag = m ? "R7" : "R6";
            slip(m ? 3 : 2);
            run(16, 1'b0);
            tag = "R9";
            slip(9);
            run(20, 1'b0);
            slip(m ? 3 : 2);
            tag = "R10";
            run(3, 1'b0);
            for (int k = 0; k < 5; k++) tick(rnd(), rnd(), 1'b0, 1'b0);
            run(4, 1'b0);
            tick(rnd(), rnd(), 1'b0, 1'b0);
            run(20, 1'b0);
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule